// File: doc/BRIEF.md
# Partitioned Battery-Backed SRAM Bus Controller

This block turns the program and data memory requests of an 8-bit microcontroller core into cycles on a non-multiplexed byte-wide SRAM bus. The lower 32 KB of the 64 KB space belongs to a primary SRAM with its own active-low chip enable. A second active-low chip enable reaches a further 32 KB that holds only data. Any access that neither SRAM serves becomes a one-cycle request to the external expanded-bus engine.

A boundary register divides the primary SRAM in two. Addresses below the boundary hold code and are write-protected. Addresses at or above it hold writable data. The boundary can be loaded at any time, so software can move it while the system runs. The two top bus address bits are driven inverted. A power-fail reset input forces every strobe inactive at once and cancels the cycle in progress.

Top module: `nvsram_bus_ctrl`

## Requirements
- R1: An instruction fetch to 0000h–7FFFh, and a data access there while `req_dsel_hi` is 0, runs a cycle on `ce1_n`. No expanded request is raised for it.
- R2: During an SRAM cycle, `ba[12:0]` equals address bits 12..0. `ba[14]` and `ba[13]` are the inverse of address bits 14 and 13.
- R3: An access with address bit 15 set pulses `xb_req` for exactly one cycle, carrying the address, the write flag and the write data. No chip enable or write strobe moves. This holds even when `req_dsel_hi` is 1.
- R4: A data access to 0000h–7FFFh while `req_dsel_hi` is 1 runs on `ce2_n` instead of `ce1_n`. An instruction fetch ignores `req_dsel_hi` and always uses `ce1_n`. The two chip enables are never low together.
- R5: A read holds its chip enable low for 4 cycles. In the cycle after that, `rsp_valid` is 1 for one cycle and `rsp_rdata` holds the `bd_i` value sampled in the last low cycle.
- R6: A write holds both its chip enable and `rw_n` low for 6 cycles, with `bd_o` equal to the write data. `bd_oe` is high during those cycles and for exactly one cycle after `rw_n` rises.
- R7: A data write on `ce1_n` whose address is below the partition boundary runs a 6-cycle chip-enable cycle, but `rw_n` stays 1 and `bd_oe` stays 0 throughout. Writes on `ce2_n` are never protected.
- R8: After reset the boundary is 8000h, so every `ce1_n` write is protected. A value loaded through `part_we`/`part_wdata` applies from the next accepted access. A boundary of 0 leaves no address protected.
- R9: While `pf_rst` is 1, `ce1_n`, `ce2_n` and `rw_n` are 1 and `bd_oe` is 0 in that same cycle. The running cycle is cancelled, and no request is accepted. The boundary register keeps its value.
- R10: A request that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_rst | input | 1 | Power-fail reset, active high |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data write (ignored for fetches) |
| req_dsel_hi | input | 1 | Steers low-half data accesses to the second chip enable |
| req_addr | input | 16 | Logical address |
| req_wdata | input | 8 | Write data |
| part_we | input | 1 | Load the partition boundary |
| part_wdata | input | 16 | New boundary value |
| ba | output | 15 | Byte-wide bus address |
| bd_o | output | 8 | Bus data driven out |
| bd_oe | output | 1 | Output enable for `bd_o` |
| bd_i | input | 8 | Bus data read in |
| ce1_n | output | 1 | Primary SRAM chip enable, active low |
| ce2_n | output | 1 | Data-only chip enable, active low |
| rw_n | output | 1 | Write strobe, active low |
| busy | output | 1 | An SRAM cycle is in progress |
| rsp_valid | output | 1 | SRAM cycle finished |
| rsp_rdata | output | 8 | Read data of the finished cycle |
| xb_req | output | 1 | Expanded-bus request pulse |
| xb_addr | output | 16 | Expanded-bus address |
| xb_write | output | 1 | Expanded-bus write flag |
| xb_wdata | output | 8 | Expanded-bus write data |

## Verification
Two events can land in the same cycle: a power-fail reset that arrives in the middle of a write, and a boundary reload while a cycle is running. The bench raises `pf_rst` two cycles into an unprotected write. It checks that the strobes and the output enable are inactive in that very cycle, that `busy` is clear on the next cycle, and that a protected write made afterwards shows the boundary survived. A second request made while a cycle is running must leave the bus with only a single 4-cycle chip-enable pulse.

// File: rtl/nvsram_bus_ctrl.sv
module nvsram_bus_ctrl #(
  parameter int AW     = 16,
  parameter int BAW    = 15,
  parameter int DW     = 8,
  parameter int RD_CYC = 4,
  parameter int WR_CYC = 6,
  parameter int INV_N  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pf_rst,
  input  logic           req_valid,
  input  logic           req_fetch,
  input  logic           req_write,
  input  logic           req_dsel_hi,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic           part_we,
  input  logic [BAW:0]   part_wdata,
  output logic [BAW-1:0] ba,
  output logic [DW-1:0]  bd_o,
  output logic           bd_oe,
  input  logic [DW-1:0]  bd_i,
  output logic           ce1_n,
  output logic           ce2_n,
  output logic           rw_n,
  output logic           busy,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           xb_req,
  output logic [AW-1:0]  xb_addr,
  output logic           xb_write,
  output logic [DW-1:0]  xb_wdata
);

  localparam int CW = $clog2(WR_CYC + 1);
  localparam logic [BAW:0] PART_RST = (BAW+1)'(1) << BAW;
  localparam logic [BAW-1:0] INV_MASK = ((BAW)'(1) << BAW) - ((BAW)'(1) << (BAW - INV_N));

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_TAIL} state_t;

  state_t         state;
  logic [CW-1:0]  cnt;
  logic [BAW:0]   part_q;
  logic           ce1_q, ce2_q, rw_q, oe_q, cur_fetch;
  logic [BAW-1:0] ba_q;
  logic [DW-1:0]  bdo_q;

  logic in_sram, use_ce2, use_ce1, wr_eff, prot, do_wr;
  logic [CW-1:0] len_m1;

  assign in_sram = (req_addr[AW-1:BAW] == '0);
  assign use_ce2 = in_sram && !req_fetch && req_dsel_hi;
  assign use_ce1 = in_sram && !use_ce2;
  assign wr_eff  = req_write && !req_fetch;
  assign prot    = use_ce1 && ({1'b0, req_addr[BAW-1:0]} < part_q);
  assign do_wr   = wr_eff && !prot;
  assign len_m1  = wr_eff ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      part_q    <= PART_RST;
      ce1_q     <= 1'b1;
      ce2_q     <= 1'b1;
      rw_q      <= 1'b1;
      oe_q      <= 1'b0;
      cur_fetch <= 1'b0;
      ba_q      <= '0;
      bdo_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      xb_req    <= 1'b0;
      xb_addr   <= '0;
      xb_write  <= 1'b0;
      xb_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      xb_req    <= 1'b0;
      if (part_we) part_q <= part_wdata;
      if (pf_rst) begin
        state <= S_IDLE;
        ce1_q <= 1'b1;
        ce2_q <= 1'b1;
        rw_q  <= 1'b1;
        oe_q  <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: if (req_valid) begin
            if (in_sram) begin
              state     <= S_ACT;
              ce1_q     <= !use_ce1;
              ce2_q     <= !use_ce2;
              rw_q      <= !do_wr;
              oe_q      <= do_wr;
              cur_fetch <= req_fetch;
              ba_q      <= req_addr[BAW-1:0] ^ INV_MASK;
              bdo_q     <= req_wdata;
              cnt       <= len_m1;
            end else begin
              xb_req   <= 1'b1;
              xb_addr  <= req_addr;
              xb_write <= wr_eff;
              xb_wdata <= req_wdata;
            end
          end
          S_ACT: begin
            if (cnt == '0) begin
              ce1_q     <= 1'b1;
              ce2_q     <= 1'b1;
              rw_q      <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_rdata <= bd_i;
              state     <= oe_q ? S_TAIL : S_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_TAIL: begin
            oe_q  <= 1'b0;
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign ce1_n = ce1_q | pf_rst;
  assign ce2_n = ce2_q | pf_rst;
  assign rw_n  = rw_q  | pf_rst;
  assign bd_oe = oe_q & ~pf_rst;
  assign ba    = ba_q;
  assign bd_o  = bdo_q;
  assign busy  = (state != S_IDLE);

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce1_n && !ce2_n)); // R4

  AST_CE2_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ce2_n |-> !cur_fetch); // R4

  AST_WR_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (!ce1_n || !ce2_n)); // R6

  AST_OE_OUTLIVES_WR: assert property (@(posedge clk) disable iff (!rst_n || pf_rst)
    $rose(rw_n) |-> bd_oe); // R6

  AST_OE_ONE_TAIL: assert property (@(posedge clk) disable iff (!rst_n || pf_rst)
    (bd_oe && rw_n) |=> !bd_oe); // R6

  AST_XB_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    xb_req |-> (ce1_n && ce2_n && rw_n)); // R3

  AST_PF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    pf_rst |=> !busy); // R9

endmodule

// File: tb/nvsram_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvsram_bus_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_rst = 1'b0;
  logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_dsel_hi = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic part_we = 1'b0;
  logic [15:0] part_wdata = '0;
  logic [14:0] ba;
  logic [7:0]  bd_o, bd_i = '0, rsp_rdata, xb_wdata;
  logic bd_oe, ce1_n, ce2_n, rw_n, busy, rsp_valid, xb_req, xb_write;
  logic [15:0] xb_addr;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  nvsram_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pf_rst(pf_rst),
    .req_valid(req_valid), .req_fetch(req_fetch), .req_write(req_write),
    .req_dsel_hi(req_dsel_hi), .req_addr(req_addr), .req_wdata(req_wdata),
    .part_we(part_we), .part_wdata(part_wdata),
    .ba(ba), .bd_o(bd_o), .bd_oe(bd_oe), .bd_i(bd_i),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .rw_n(rw_n), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .xb_req(xb_req), .xb_addr(xb_addr), .xb_write(xb_write), .xb_wdata(xb_wdata)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] bus_addr(input logic [15:0] a);
    return {~a[14], ~a[13], a[12:0]};
  endfunction

  // kind: 0 = ce1, 1 = ce2, 2 = expanded
  typedef struct packed {
    logic [15:0] addr;
    logic        fetch;
    logic        wr;
    logic        dsel;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [1:0]  kind;
    logic [3:0]  cec;
    logic [3:0]  rwc;
    logic [3:0]  oec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'h0123, 1'b1, 1'b0, 1'b0, 8'h00, 8'h3C, 2'd0, 4'd4, 4'd0, 4'd0},
    '{16'h7ABC, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A, 2'd0, 4'd4, 4'd0, 4'd0},
    '{16'h2000, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 2'd0, 4'd6, 4'd6, 4'd7},
    '{16'h0800, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00, 2'd0, 4'd6, 4'd0, 4'd0},
    '{16'h0800, 1'b0, 1'b1, 1'b1, 8'h22, 8'h00, 2'd1, 4'd6, 4'd6, 4'd7},
    '{16'h7FFF, 1'b0, 1'b0, 1'b1, 8'h00, 8'hC3, 2'd1, 4'd4, 4'd0, 4'd0},
    '{16'h0100, 1'b1, 1'b0, 1'b1, 8'h00, 8'h77, 2'd0, 4'd4, 4'd0, 4'd0},
    '{16'h8000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 2'd2, 4'd0, 4'd0, 4'd0},
    '{16'hFFFF, 1'b0, 1'b1, 1'b0, 8'h9E, 8'h00, 2'd2, 4'd0, 4'd0, 4'd0},
    '{16'h9000, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 2'd2, 4'd0, 4'd0, 4'd0},
    '{16'h0FFF, 1'b0, 1'b1, 1'b0, 8'h33, 8'h00, 2'd0, 4'd6, 4'd0, 4'd0},
    '{16'h1000, 1'b0, 1'b1, 1'b0, 8'h44, 8'h00, 2'd0, 4'd6, 4'd6, 4'd7}
  };

  int c1, c2, rwc, oec, xbc, rspc, bad_ba, bad_bd, bad_x;
  logic [7:0] rsp_seen;

  task automatic run_access(input vec_t v, input bit inject_second);
    c1 = 0; c2 = 0; rwc = 0; oec = 0; xbc = 0; rspc = 0;
    bad_ba = 0; bad_bd = 0; bad_x = 0; rsp_seen = '0;
    @(negedge clk);
    req_addr = v.addr; req_fetch = v.fetch; req_write = v.wr;
    req_dsel_hi = v.dsel; req_wdata = v.wd; bd_i = v.rd; req_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      req_valid = (inject_second && k == 1);
      if (!ce1_n) c1++;
      if (!ce2_n) c2++;
      if (!rw_n) begin rwc++; if (bd_o != v.wd) bad_bd++; end
      if (bd_oe) oec++;
      if ((!ce1_n || !ce2_n) && ba != bus_addr(v.addr)) bad_ba++;
      if (rsp_valid) begin rspc++; rsp_seen = rsp_rdata; end
      if (xb_req) begin
        xbc++;
        if (xb_addr != v.addr || xb_write != (v.wr && !v.fetch) || xb_wdata != v.wd) bad_x++;
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    check(ce1_n && ce2_n && rw_n && !bd_oe && !busy && !xb_req && !rsp_valid,
          "reset state R9", {ce1_n, ce2_n, rw_n, bd_oe, busy}, 5'b11100);
    rst_n = 1'b1;

    // R8: reset boundary protects the whole primary SRAM
    v = '{16'h7FFF, 1'b0, 1'b1, 1'b0, 8'h66, 8'h00, 2'd0, 4'd6, 4'd0, 4'd0};
    run_access(v, 1'b0);
    check(c1 == 6 && rwc == 0 && oec == 0, "R8 reset boundary protects 7FFF", rwc, 0);

    @(negedge clk); part_we = 1'b1; part_wdata = 16'h1000;
    @(negedge clk); part_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run_access(v, 1'b0);
      if (v.kind == 2'd2) begin
        check(xbc == 1 && bad_x == 0, $sformatf("R3 xb pulse vec%0d", i), xbc, 1);
        check(c1 == 0 && c2 == 0 && rwc == 0, $sformatf("R3 no strobe vec%0d", i), c1 + c2 + rwc, 0);
      end else begin
        check(xbc == 0, $sformatf("R1 no xb on sram vec%0d", i), xbc, 0);
        if (v.kind == 2'd0)
          check(c1 == v.cec && c2 == 0, $sformatf("R1 R5 ce1 length vec%0d", i), c1, v.cec);
        else
          check(c2 == v.cec && c1 == 0, $sformatf("R4 ce2 length vec%0d", i), c2, v.cec);
        check(bad_ba == 0, $sformatf("R2 bus address vec%0d", i), bad_ba, 0);
        check(rwc == v.rwc && bad_bd == 0, $sformatf("R6 R7 write strobe vec%0d", i), rwc, v.rwc);
        check(oec == v.oec, $sformatf("R6 R7 output enable vec%0d", i), oec, v.oec);
        check(rspc == 1, $sformatf("R5 one response vec%0d", i), rspc, 1);
        if (!v.wr || v.fetch)
          check(rsp_seen == v.rd, $sformatf("R5 read data vec%0d", i), rsp_seen, v.rd);
      end
    end

    // R8: boundary 0 unprotects everything
    @(negedge clk); part_we = 1'b1; part_wdata = 16'h0000;
    @(negedge clk); part_we = 1'b0;
    v = '{16'h0000, 1'b0, 1'b1, 1'b0, 8'h5C, 8'h00, 2'd0, 4'd6, 4'd6, 4'd7};
    run_access(v, 1'b0);
    check(rwc == 6 && oec == 7, "R8 boundary zero writable", rwc, 6);

    // R10: second request while busy ignored
    v = '{16'h0042, 1'b1, 1'b0, 1'b0, 8'h00, 8'h81, 2'd0, 4'd4, 4'd0, 4'd0};
    run_access(v, 1'b1);
    check(c1 == 4 && rspc == 1, "R10 request during busy ignored", c1, 4);

    // R9: power-fail in the middle of a write
    @(negedge clk); part_we = 1'b1; part_wdata = 16'h4000;
    @(negedge clk); part_we = 1'b0;
    req_addr = 16'h5000; req_fetch = 1'b0; req_write = 1'b1; req_dsel_hi = 1'b0;
    req_wdata = 8'hE7; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check(!rw_n && !ce1_n && bd_oe, "R6 write started before pf", rw_n, 0);
    @(negedge clk);
    pf_rst = 1'b1;
    #0.5;
    check(ce1_n && ce2_n && rw_n && !bd_oe, "R9 strobes inactive same cycle",
          {ce1_n, ce2_n, rw_n, bd_oe}, 4'b1110);
    req_valid = 1'b1; req_addr = 16'h0010; req_write = 1'b0;
    @(negedge clk);
    check(!busy, "R9 cycle cancelled", busy, 0);
    @(negedge clk);
    check(!busy && ce1_n && ce2_n, "R9 request during pf ignored", busy, 0);
    req_valid = 1'b0; pf_rst = 1'b0;
    repeat (2) @(negedge clk);
    check(ce1_n && ce2_n && rw_n && !bd_oe && !busy, "R9 idle after pf release", busy, 0);

    // R9: boundary survives power-fail
    v = '{16'h3FFF, 1'b0, 1'b1, 1'b0, 8'h12, 8'h00, 2'd0, 4'd6, 4'd0, 4'd0};
    run_access(v, 1'b0);
    check(c1 == 6 && rwc == 0 && oec == 0, "R9 R7 boundary kept after pf", rwc, 0);
    v = '{16'h4000, 1'b0, 1'b1, 1'b0, 8'h34, 8'h00, 2'd0, 4'd6, 4'd6, 4'd7};
    run_access(v, 1'b0);
    check(rwc == 6 && bad_bd == 0, "R8 boundary edge writable", rwc, 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule